// File: doc/BRIEF.md
# PRBS Built-In Self-Test Engine

This block runs a pattern self-test across a 4-bit PHY data path. Once started, a pseudo-random generator sends nibbles toward the transmit side. A second generator, seeded with the same value, predicts what should come back on the receive side and compares each returned nibble against that prediction. One sticky status bit reports the outcome. It reads fail until at least one nibble has matched, and it stays at fail after any mismatch until the next start.

The engine is driven through a 16-bit control word. Bit 8 starts or stops a run. Bit 0 selects the short 9-bit sequence in place of the 15-bit one. Bit 1 selects gapless streaming in place of packets separated by idle gaps. The status bit reads back at bit 9 of the same word. Packet length and gap length are parameters. The loopback path, line coding and analog front end lie outside the block.

Top module: `prbs_bist`

## Requirements
- R1: After reset, `tx_valid` is 0, `bist_pass` is 0 and `ctrl_rdata` is all zeros.
- R2: A write with bit 8 set starts a run. Both sequence generators are reseeded to all ones, and on the edge that samples the write `bist_pass` clears to 0, `tx_valid` drops to 0 and the packet position restarts.
- R3: With bit 0 of the starting word clear, the transmitted bits follow b[n] = b[n-15] XOR b[n-14] (polynomial x^15+x^14+1) from an all-ones history. Each nibble carries four consecutive bits, and the earliest bit is in bit 3.
- R4: With bit 0 of the starting word set, the bits follow b[n] = b[n-9] XOR b[n-5] (polynomial x^9+x^5+1) from an all-ones history, with the same nibble packing as R3.
- R5: In packet mode (bit 1 clear), the first nibble is sent on the clock edge after the start edge. `tx_valid` is then high for PKT_LEN consecutive cycles and low for GAP_LEN cycles, and this pattern repeats.
- R6: In continuous mode (bit 1 set), `tx_valid` is high on every cycle of a run except the cycles of a control write.
- R7: The checker compares only cycles in which `rx_valid` is high. The first valid nibble after a start is compared with the first nibble of the sequence, and each following valid nibble with the next one. Data seen while `rx_valid` is low has no effect.
- R8: `bist_pass` rises to 1 on the edge of the first matching comparison after a start, provided no mismatch has occurred since that start.
- R9: A mismatch forces `bist_pass` to 0 and holds it there, even through later matches, until the next write with bit 8 set.
- R10: A write with bit 8 clear stops the run. From the edge that samples it, `tx_valid` stays 0, no nibble is compared and `bist_pass` keeps its value. No nibble is sent or compared in any cycle that carries a control write.
- R11: `ctrl_rdata` shows the status at bit 9, the running flag at bit 8, the continuous flag at bit 1 and the short-sequence flag at bit 0. All other bits read 0. The mode flags are taken from the word that started the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: bit 8 run, bit 1 continuous, bit 0 short sequence |
| ctrl_rdata | output | 16 | Control readback with the status at bit 9 |
| bist_pass | output | 1 | Sticky pass (1) / fail (0) status |
| tx_data | output | 4 | Generated nibble toward the transmit path |
| tx_valid | output | 1 | Qualifies tx_data |
| rx_data | input | 4 | Returned nibble from the receive path |
| rx_valid | input | 1 | Qualifies rx_data |

## Verification
A corrupted transmit generator state changes `tx_data` on the next valid nibble, so the per-cycle model comparison catches it within one cycle. A fault in the packet pacing counter moves `tx_valid` away from its 16/4 rhythm within one packet period. A checker that falls out of step raises a mismatch on the next valid returned nibble, and `bist_pass` then drops one edge later. A status latch that loses its sticky behaviour shows as `bist_pass` returning to 1 after an injected error.

// File: rtl/prbs_bist_pkg.sv
// Shared constants and the nibble step function for the PRBS self-test.
// Assumes the short sequence fits inside the long state register.
package prbs_bist_pkg;
    localparam int NIB_W     = 4;
    localparam int REG_W     = 16;
    localparam int LONG_W    = 15;
    localparam int LONG_TAP  = 14;
    localparam int SHORT_W   = 9;
    localparam int SHORT_TAP = 5;
    localparam int RUN_BIT   = 8;
    localparam int STAT_BIT  = 9;
    localparam int CONT_BIT  = 1;
    localparam int SHORT_BIT = 0;

    localparam logic [LONG_W-1:0] SEED       = '1;
    localparam logic [LONG_W-1:0] SHORT_MASK = LONG_W'((1 << SHORT_W) - 1);

    typedef struct packed {
        logic [NIB_W-1:0]  nib;
        logic [LONG_W-1:0] state;
    } step_t;

    // Advance the selected Fibonacci register by NIB_W bits; first bit lands in the MSB.
    function automatic step_t prbs_step(input logic [LONG_W-1:0] s_in, input logic short_sel);
        step_t r;
        logic [LONG_W-1:0] s;
        logic nb;
        s     = s_in;
        r.nib = '0;
        for (int i = 0; i < NIB_W; i++) begin
            if (short_sel) nb = s[SHORT_W-1] ^ s[SHORT_TAP-1];
            else           nb = s[LONG_W-1]  ^ s[LONG_TAP-1];
            s = {s[LONG_W-2:0], nb};
            if (short_sel) s = s & SHORT_MASK;
            r.nib[NIB_W-1-i] = nb;
        end
        r.state = s;
        return r;
    endfunction
endpackage

// File: rtl/prbs_bist_ctrl.sv
// Control word decode, run/mode flags and the sticky pass/fail status.
// Assumes cmp_vld_i/cmp_bad_i come from the checker in the same cycle.
module prbs_bist_ctrl
    import prbs_bist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             run_bit_i,
    input  logic             cont_bit_i,
    input  logic             short_bit_i,
    input  logic             cmp_vld_i,
    input  logic             cmp_bad_i,
    output logic             start_o,
    output logic             go_o,
    output logic             cont_o,
    output logic             short_o,
    output logic             pass_o,
    output logic [REG_W-1:0] rdata_o
);
    logic run_q, cont_q, short_q, pass_q, err_q;

    assign start_o = wr_i && run_bit_i;
    assign go_o    = run_q && !wr_i;
    assign cont_o  = cont_q;
    assign short_o = short_q;
    assign pass_o  = pass_q;

    // Running flag follows each write of the start/stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 1'b0;
        else if (wr_i) run_q <= run_bit_i;
    end

    // Mode flags are captured from the starting word only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q  <= 1'b0;
            short_q <= 1'b0;
        end else if (start_o) begin
            cont_q  <= cont_bit_i;
            short_q <= short_bit_i;
        end
    end

    // Sticky status: cleared on start, set by a match, locked low by a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_o) begin
            pass_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (cmp_vld_i) begin
            if (cmp_bad_i) begin
                err_q  <= 1'b1;
                pass_q <= 1'b0;
            end else if (!err_q) begin
                pass_q <= 1'b1;
            end
        end
    end

    // Readback word assembly.
    always_comb begin
        rdata_o            = '0;
        rdata_o[STAT_BIT]  = pass_q;
        rdata_o[RUN_BIT]   = run_q;
        rdata_o[CONT_BIT]  = cont_q;
        rdata_o[SHORT_BIT] = short_q;
    end

    // R2
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !pass_o);
    // R9
    sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !start_o) |=> !pass_o);
    // R8
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o && !start_o && !(cmp_vld_i && cmp_bad_i)) |=> pass_o);
endmodule

// File: rtl/prbs_bist_gen.sv
// Transmit pattern generator with packet/gap pacing or gapless streaming.
// Assumes GAP_LEN >= 1 and that mode inputs change only on start.
module prbs_bist_gen
    import prbs_bist_pkg::*;
#(
    parameter int PKT_LEN = 16,
    parameter int GAP_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             go_i,
    input  logic             cont_i,
    input  logic             short_i,
    output logic [NIB_W-1:0] tx_data_o,
    output logic             tx_valid_o
);
    localparam int PERIOD = PKT_LEN + GAP_LEN;
    localparam int CNT_W  = $clog2(PERIOD);

    logic [LONG_W-1:0] lfsr_q;
    logic [CNT_W-1:0]  cnt_q;
    step_t             nxt;
    logic              emit;

    assign nxt  = prbs_step(lfsr_q, short_i);
    assign emit = go_i && (cont_i || (cnt_q < CNT_W'(PKT_LEN)));

    // Sequence state: reseed on start, advance per emitted nibble.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) lfsr_q <= SEED;
        else if (emit)         lfsr_q <= nxt.state;
    end

    // Position within the packet-plus-gap period.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)                   cnt_q <= '0;
        else if (go_i && cnt_q == CNT_W'(PERIOD-1)) cnt_q <= '0;
        else if (go_i)                           cnt_q <= cnt_q + 1'b1;
    end

    // Registered transmit outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            tx_data_o  <= '0;
        end else if (start_i) begin
            tx_valid_o <= 1'b0;
        end else begin
            tx_valid_o <= emit;
            if (emit) tx_data_o <= nxt.nib;
        end
    end

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> !tx_valid_o);
    // R6
    cont_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && cont_i) |=> tx_valid_o);
endmodule

// File: rtl/prbs_bist_chk.sv
// Receive checker: predicts each valid nibble and flags mismatches.
// Assumes the returned stream starts with the first generated nibble.
module prbs_bist_chk
    import prbs_bist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             go_i,
    input  logic             short_i,
    input  logic [NIB_W-1:0] rx_data_i,
    input  logic             rx_valid_i,
    output logic             cmp_vld_o,
    output logic             cmp_bad_o
);
    logic [LONG_W-1:0] lfsr_q;
    step_t             exp_s;

    assign exp_s     = prbs_step(lfsr_q, short_i);
    assign cmp_vld_o = go_i && rx_valid_i;
    assign cmp_bad_o = cmp_vld_o && (rx_data_i != exp_s.nib);

    // Expected-sequence state: reseed on start, advance per compared nibble.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) lfsr_q <= SEED;
        else if (cmp_vld_o)    lfsr_q <= exp_s.state;
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid_i && !start_i) |=> $stable(lfsr_q));
endmodule

// File: rtl/prbs_bist.sv
// Top of the PRBS self-test engine: control, generator and checker.
// Assumes a single clock for both data directions.
module prbs_bist
    import prbs_bist_pkg::*;
#(
    parameter int PKT_LEN = 16,
    parameter int GAP_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [15:0] ctrl_wdata,
    output logic [15:0] ctrl_rdata,
    output logic        bist_pass,
    output logic [3:0]  tx_data,
    output logic        tx_valid,
    input  logic [3:0]  rx_data,
    input  logic        rx_valid
);
    logic start, go, cont, short_sel, cmp_vld, cmp_bad;

    prbs_bist_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr),
        .run_bit_i(ctrl_wdata[RUN_BIT]), .cont_bit_i(ctrl_wdata[CONT_BIT]),
        .short_bit_i(ctrl_wdata[SHORT_BIT]),
        .cmp_vld_i(cmp_vld), .cmp_bad_i(cmp_bad),
        .start_o(start), .go_o(go), .cont_o(cont), .short_o(short_sel),
        .pass_o(bist_pass), .rdata_o(ctrl_rdata)
    );

    prbs_bist_gen #(.PKT_LEN(PKT_LEN), .GAP_LEN(GAP_LEN)) u_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start), .go_i(go),
        .cont_i(cont), .short_i(short_sel),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid)
    );

    prbs_bist_chk u_chk (
        .clk(clk), .rst_n(rst_n), .start_i(start), .go_i(go),
        .short_i(short_sel), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
        .cmp_vld_o(cmp_vld), .cmp_bad_o(cmp_bad)
    );
endmodule

// File: tb/prbs_bist_bench.sv
module prbs_bist_bench;
    localparam int PKT = 16;
    localparam int GAP = 4;
    localparam int DLY = 3;
    localparam int WD  = 20000;

    logic clk = 0;
    logic rst_n = 0;
    logic ctrl_wr = 0;
    logic [15:0] ctrl_wdata = 0;
    logic [15:0] ctrl_rdata;
    logic bist_pass;
    logic [3:0] tx_data;
    logic tx_valid;
    logic [3:0] rx_data = 0;
    logic rx_valid = 0;

    always #10 clk = ~clk;

    prbs_bist #(.PKT_LEN(PKT), .GAP_LEN(GAP)) u_prbs_bist (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .bist_pass(bist_pass), .tx_data(tx_data),
        .tx_valid(tx_valid), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit comparing = 0;
    bit inj = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_run = 0, m_cont = 0, m_short = 0, m_pass = 0, m_err = 0, m_txv = 0;
    logic [3:0] m_txd = 0;
    int m_beat = 0;
    bit gq[$];
    bit cq[$];

    function automatic void refill();
        gq.delete(); cq.delete();
        for (int i = 0; i < 15; i++) begin gq.push_back(1'b1); cq.push_back(1'b1); end
    endfunction

    function automatic logic [3:0] draw(input bit which);
        logic [3:0] n;
        n = 0;
        for (int i = 0; i < 4; i++) begin
            bit b;
            if (which == 0) begin
                b = m_short ? (gq[gq.size()-9] ^ gq[gq.size()-5]) : (gq[gq.size()-15] ^ gq[gq.size()-14]);
                gq.push_back(b); void'(gq.pop_front());
            end else begin
                b = m_short ? (cq[cq.size()-9] ^ cq[cq.size()-5]) : (cq[cq.size()-15] ^ cq[cq.size()-14]);
                cq.push_back(b); void'(cq.pop_front());
            end
            n[3-i] = b;
        end
        return n;
    endfunction

    always @(posedge clk) begin
        bit sw, go;
        logic [3:0] e;
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_cont = 0; m_short = 0; m_pass = 0; m_err = 0; m_txv = 0; m_txd = 0; m_beat = 0;
            refill();
        end else begin
            sw = ctrl_wr && ctrl_wdata[8];
            go = m_run && !ctrl_wr;
            if (sw) begin
                refill();
                m_run = 1; m_cont = ctrl_wdata[1]; m_short = ctrl_wdata[0];
                m_pass = 0; m_err = 0; m_txv = 0; m_beat = 0;
            end else begin
                if (go && rx_valid) begin
                    e = draw(1);
                    if (e != rx_data) begin m_err = 1; m_pass = 0; end
                    else if (!m_err) m_pass = 1;
                end
                if (go) begin
                    if (m_cont || m_beat < PKT) begin m_txv = 1; m_txd = draw(0); end
                    else m_txv = 0;
                    m_beat = (m_beat + 1) % (PKT + GAP);
                end else m_txv = 0;
                if (ctrl_wr) m_run = 0;
            end
        end
        if (cyc >= WD && !done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected<%0d", cyc, WD);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- per-cycle compare and loopback drive ----------------
    logic dv [DLY];
    logic [3:0] dd [DLY];
    initial for (int i = 0; i < DLY; i++) begin dv[i] = 0; dd[i] = 0; end

    always @(negedge clk) begin
        logic v;
        logic [3:0] d;
        if (rst_n && comparing) begin
            check(tx_valid == m_txv, m_cont ? "R6" : (m_run ? "R5" : "R10"), tx_valid, m_txv);
            if (m_txv) check(tx_data == m_txd, m_short ? "R4" : "R3", tx_data, m_txd);
            check(bist_pass == m_pass, m_err ? "R9" : "R8", bist_pass, m_pass);
            check(ctrl_rdata == {6'b0, m_pass, m_run, 6'b0, m_cont, m_short}, "R11",
                  ctrl_rdata, {6'b0, m_pass, m_run, 6'b0, m_cont, m_short});
        end
        v = dv[DLY-1]; d = dd[DLY-1];
        for (int i = DLY-1; i > 0; i--) begin dv[i] = dv[i-1]; dd[i] = dd[i-1]; end
        dv[0] = tx_valid; dd[0] = tx_data;
        if (v && inj) begin d = d ^ 4'b0001; inj = 0; end
        if (!v) d = 4'(cyc * 7 + 3);   // R7 garbage on idle cycles
        rx_valid = v; rx_data = d;
    end

    task automatic wr(input logic [15:0] w);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = w;
        @(negedge clk); ctrl_wr = 0; ctrl_wdata = 0;
    endtask

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(tx_valid == 0, "R1", tx_valid, 0);
        check(bist_pass == 0, "R1", bist_pass, 0);
        check(ctrl_rdata == 0, "R1", ctrl_rdata, 0);
        comparing = 1;

        // 15-bit sequence, packet mode
        wr(16'h0100);
        check(bist_pass == 0, "R2", bist_pass, 0);
        repeat (20) @(negedge clk);
        cnt = 0;
        repeat (5 * (PKT + GAP)) begin @(negedge clk); if (tx_valid) cnt++; end
        check(cnt == 5 * PKT, "R5", cnt, 5 * PKT);
        check(bist_pass == 1, "R7", bist_pass, 1);

        // single corrupted nibble
        inj = 1;
        repeat (40) @(negedge clk);
        check(bist_pass == 0, "R9", bist_pass, 0);

        // stop
        wr(16'h0000);
        repeat (10) @(negedge clk);
        check(tx_valid == 0, "R10", tx_valid, 0);
        check(ctrl_rdata[8] == 0, "R11", ctrl_rdata[8], 0);

        // 9-bit sequence, continuous
        wr(16'h0103);
        check(bist_pass == 0, "R2", bist_pass, 0);
        @(negedge clk);
        cnt = 0;
        repeat (50) begin @(negedge clk); if (tx_valid) cnt++; end
        check(cnt == 50, "R6", cnt, 50);
        repeat (20) @(negedge clk);
        check(bist_pass == 1, "R8", bist_pass, 1);

        // stop holds a pass
        wr(16'h0000);
        repeat (10) @(negedge clk);
        check(bist_pass == 1, "R10", bist_pass, 1);

        // restart clears the pass
        wr(16'h0100);
        check(bist_pass == 0, "R2", bist_pass, 0);
        repeat (60) @(negedge clk);
        check(bist_pass == 1, "R3", bist_pass, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule